// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This core is the host side of an SMBus controller. Software fills a small byte-wide register file with a target address, a command byte, data bytes and a block length. It then writes a start request that carries a protocol code. From that request the core runs the complete transaction as a series of byte-level operations on a bus port: start condition, send byte, receive byte with ack or nack, and stop condition. A bit-level engine on the other side of that port returns a done pulse for each operation, together with the target's acknowledge and an arbitration-loss flag.

The core supports six protocols: quick, byte, byte-data, word-data, process call and block. A block transfer holds up to 32 bytes, but the register file has only an eight-byte data window. The transfer therefore moves in chunks of eight. After each full chunk the core raises a sticky chunk flag and pauses until software clears it. During the pause software refills the window on a write, or drains it on a read. Outcomes are reported in sticky status bits that software clears by writing ones: completion, device error (a nack) and collision (arbitration loss). A kill request drops the transaction at once.

Top module: `smbus_host`

## Requirements
- R1: After reset, status, control, host control, address, command and count read zero, and no bus request is made.
- R2: Protocol code 0 (quick) issues start, sends the address register exactly as written, issues stop, and then sets completion (status bit 3).
- R3: Every other protocol issues start, sends the address with bit 0 cleared, then sends the command byte. Byte (1) with address bit 0 low stops after the command. Byte-data (2) in write form sends window byte 0. Word (3) in write form sends window byte 0 and then window byte 1. Each then issues stop and sets completion.
- R4: A byte, byte-data or word read (address bit 0 high) issues a repeated start after the command, sends the address with bit 0 set, and receives one byte (codes 1 and 2) or two bytes (code 3) into window bytes 0 and 1 in order. Every received byte is acked except the last, which is nacked. Stop follows.
- R5: A process call (4) sends window bytes 0 and 1 after the command, then issues a repeated start and reads two bytes back into window bytes 0 and 1. This happens whatever the address bit 0.
- R6: A block write (5, address bit 0 low) sends the count register, clipped to 32, as the first data byte. It then sends window byte i mod 8 for byte i. After every eighth byte, if more bytes remain, it sets chunk-done (status bit 4) and sends nothing until software clears that bit. A count of zero stops straight after the count byte.
- R7: A block read (5, address bit 0 high) acks the first received byte, clips it to 32 and stores it in the count register (offset 7). Byte i goes into window byte i mod 8, with the same chunk-done pause after every full chunk. The last byte is nacked.
- R8: A nack on any sent byte sets device error (status bit 1), issues stop and ends the transaction without completion.
- R9: Arbitration loss on any operation sets collision (status bit 2) and returns to idle without issuing stop.
- R10: Status bits 4 to 1 stay set until a write with a one in their position. A write with zero in a position leaves that bit unchanged.
- R11: Host busy (control bit 0) is high from an accepted start until the stop completes. While busy, a start request is ignored, and the host control register keeps the protocol code of the running transaction.
- R12: Writing host control (offset 3) with bit 5 set returns the core to idle on the next cycle, with busy low, and no further bus operation is issued.
- R13: A start request with protocol code 6 or 7 is ignored: busy stays low and no bus operation is issued.
- R14: Control bits 6 and 5 are plain read/write storage. Control bit 1 reads high while the core holds the bus (from start completion to stop completion). Control bits 1 and 0 ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register offset; offsets 8 to 15 are the data window |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational on regAddr) |
| busReq | output | 1 | One-cycle request for a byte-level bus operation |
| busOp | output | 2 | Operation: 0 start, 1 send, 2 receive, 3 stop |
| busTxByte | output | 8 | Byte to send for a send operation |
| busRxAck | output | 1 | For a receive: 1 acks the byte, 0 nacks it |
| busDone | input | 1 | One-cycle completion pulse of the requested operation |
| busAck | input | 1 | Target acknowledge for a send, valid with busDone |
| busLost | input | 1 | Arbitration lost, valid with busDone |
| busRxByte | input | 8 | Received byte, valid with busDone |

## Verification
Most faults in the phase sequencer show up in the order or content of bus operations. The bench therefore compares every request against an expected stream at the moment the request is issued. A wrong next phase, a wrong byte index or a flipped ack bit is reported at the first operation that goes wrong, often within a handful of cycles of the cause. Faults in the chunk handshake or in length clipping show up at a chunk boundary: the bus runs past a pause, stalls forever, or leaves the wrong value in the count register or window. Faults in the status logic show up on the next status read after a transaction ends.

// File: rtl/smbus_host_pkg.sv
package smbus_host_pkg;

  localparam int WIN_BYTES = 8;
  localparam int WIN_IDX_W = $clog2(WIN_BYTES);
  localparam int REG_AW    = WIN_IDX_W + 1;
  localparam int MAX_BLOCK = 32;
  localparam int LEN_W     = $clog2(MAX_BLOCK + 1);

  localparam logic [REG_AW-1:0] OFS_STATUS = REG_AW'(0);
  localparam logic [REG_AW-1:0] OFS_CTRL   = REG_AW'(2);
  localparam logic [REG_AW-1:0] OFS_HOST   = REG_AW'(3);
  localparam logic [REG_AW-1:0] OFS_ADDR   = REG_AW'(4);
  localparam logic [REG_AW-1:0] OFS_CMD    = REG_AW'(5);
  localparam logic [REG_AW-1:0] OFS_COUNT  = REG_AW'(7);

  localparam int ST_ERR   = 1;
  localparam int ST_COLL  = 2;
  localparam int ST_CMPL  = 3;
  localparam int ST_CHUNK = 4;
  localparam logic [7:0] ST_W1C_MASK = 8'h1E;

  localparam logic [2:0] PROTO_QUICK = 3'd0;
  localparam logic [2:0] PROTO_BYTE  = 3'd1;
  localparam logic [2:0] PROTO_BDATA = 3'd2;
  localparam logic [2:0] PROTO_WORD  = 3'd3;
  localparam logic [2:0] PROTO_PCALL = 3'd4;
  localparam logic [2:0] PROTO_BLOCK = 3'd5;

  typedef enum logic [1:0] {
    BUS_START = 2'd0,
    BUS_SEND  = 2'd1,
    BUS_RECV  = 2'd2,
    BUS_STOP  = 2'd3
  } busOp_e;

  // strobes from the sequencer to the register datapath
  typedef struct packed {
    logic                 setCmpl;
    logic                 setErr;
    logic                 setColl;
    logic                 setChunk;
    logic                 wrWin;
    logic [WIN_IDX_W-1:0] winIdx;
    logic                 wrCount;
    logic [LEN_W-1:0]     countVal;
  } dpStrb_t;

  function automatic logic [LEN_W-1:0] clipLen(input logic [7:0] raw);
    return (raw > 8'(MAX_BLOCK)) ? LEN_W'(MAX_BLOCK) : raw[LEN_W-1:0];
  endfunction

endpackage

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
  import smbus_host_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [7:0]           regWrData,
  output logic [7:0]           regRdData,
  input  dpStrb_t              strb,
  input  logic [7:0]           rxByte,
  input  logic                 busy,
  input  logic                 engaged,
  input  logic [WIN_IDX_W-1:0] winSel,
  output logic                 startStrobe,
  output logic                 killStrobe,
  output logic [2:0]           startProto,
  output logic [7:0]           addrByte,
  output logic [7:0]           cmdByte,
  output logic [7:0]           countByte,
  output logic [7:0]           winByte,
  output logic                 chunkFlag
);

  logic [7:0] statusReg, statusNext;
  logic [1:0] ctlBits;
  logic [2:0] hostProto;
  logic [7:0] addrReg, cmdReg, countReg;
  logic [7:0] win [WIN_BYTES];

  logic                 winHit;
  logic [WIN_IDX_W-1:0] winOfs;
  logic                 stWr, ctlWr, hostWr, addrWr, cmdWr, cntWr;

  assign winHit = regAddr[REG_AW-1];
  assign winOfs = regAddr[WIN_IDX_W-1:0];
  assign stWr   = regWrEn && (regAddr == OFS_STATUS);
  assign ctlWr  = regWrEn && (regAddr == OFS_CTRL);
  assign hostWr = regWrEn && (regAddr == OFS_HOST);
  assign addrWr = regWrEn && (regAddr == OFS_ADDR);
  assign cmdWr  = regWrEn && (regAddr == OFS_CMD);
  assign cntWr  = regWrEn && (regAddr == OFS_COUNT);

  assign killStrobe  = hostWr && regWrData[5];
  assign startStrobe = hostWr && regWrData[4] && !regWrData[5];
  assign startProto  = regWrData[2:0];

  // sticky status: hardware set wins over a same-cycle software clear
  always_comb begin
    statusNext = statusReg;
    if (stWr) statusNext = statusReg & ~(regWrData & ST_W1C_MASK);
    if (strb.setCmpl)  statusNext[ST_CMPL]  = 1'b1;
    if (strb.setErr)   statusNext[ST_ERR]   = 1'b1;
    if (strb.setColl)  statusNext[ST_COLL]  = 1'b1;
    if (strb.setChunk) statusNext[ST_CHUNK] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= '0;
      ctlBits   <= '0;
      hostProto <= '0;
      addrReg   <= '0;
      cmdReg    <= '0;
      countReg  <= '0;
    end else begin
      statusReg <= statusNext;
      if (ctlWr) ctlBits <= regWrData[6:5];
      if (hostWr && !busy) hostProto <= regWrData[2:0];
      if (addrWr) addrReg <= regWrData;
      if (cmdWr) cmdReg <= regWrData;
      if (strb.wrCount) countReg <= 8'(strb.countVal);
      else if (cntWr) countReg <= regWrData;
    end
  end

  for (genvar g = 0; g < WIN_BYTES; g++) begin : gWin
    always_ff @(posedge clk) begin
      if (!rstN) win[g] <= '0;
      else if (strb.wrWin && strb.winIdx == WIN_IDX_W'(g)) win[g] <= rxByte;
      else if (regWrEn && winHit && winOfs == WIN_IDX_W'(g)) win[g] <= regWrData;
    end
  end

  always_comb begin
    regRdData = '0;
    if (winHit) regRdData = win[winOfs];
    else begin
      case (regAddr)
        OFS_STATUS: regRdData = statusReg;
        OFS_CTRL:   regRdData = {1'b0, ctlBits, 3'b000, engaged, busy};
        OFS_HOST:   regRdData = {5'b0, hostProto};
        OFS_ADDR:   regRdData = addrReg;
        OFS_CMD:    regRdData = cmdReg;
        OFS_COUNT:  regRdData = countReg;
        default:    regRdData = '0;
      endcase
    end
  end

  assign addrByte  = addrReg;
  assign cmdByte   = cmdReg;
  assign countByte = countReg;
  assign winByte   = win[winSel];
  assign chunkFlag = statusReg[ST_CHUNK];

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.setErr |=> statusReg[ST_ERR]);

  assert_count_clip_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCount |=> (countReg <= 8'(MAX_BLOCK)));

  assert_chunk_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.setChunk |=> chunkFlag);

  assert_w1c_keep_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stWr && !regWrData[ST_COLL] && statusReg[ST_COLL]) |=> statusReg[ST_COLL]);

endmodule

// File: rtl/smbus_host_ctrl.sv
module smbus_host_ctrl
  import smbus_host_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startStrobe,
  input  logic                 killStrobe,
  input  logic [2:0]           startProto,
  input  logic [7:0]           addrByte,
  input  logic [7:0]           cmdByte,
  input  logic [7:0]           countByte,
  input  logic [7:0]           winByte,
  input  logic                 chunkFlag,
  output logic                 busReq,
  output busOp_e               busOp,
  output logic [7:0]           busTxByte,
  output logic                 busRxAck,
  input  logic                 busDone,
  input  logic                 busAck,
  input  logic                 busLost,
  input  logic [7:0]           busRxByte,
  output dpStrb_t              strb,
  output logic [WIN_IDX_W-1:0] winSel,
  output logic                 busy,
  output logic                 engaged
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_HOLD} state_e;
  typedef enum logic [3:0] {
    PH_START, PH_QADDR, PH_ADDRW, PH_CMD, PH_BCOUNT, PH_WDATA,
    PH_RSTART, PH_ADDRR, PH_RCOUNT, PH_RDATA, PH_STOP
  } phase_e;

  state_e           state, nState;
  phase_e           phase, nPhase;
  logic [2:0]       proto, nProto;
  logic             rdMode, nRd;
  logic [7:0]       addrLat, nAddr;
  logic [LEN_W-1:0] idx, nIdx, len, nLen, total, rxLen;
  logic             errEnd, nErr, nEng;
  logic             lastByte, chunkEdge;

  always_comb begin
    unique case (proto)
      PROTO_BYTE, PROTO_BDATA: total = LEN_W'(1);
      PROTO_WORD, PROTO_PCALL: total = LEN_W'(2);
      PROTO_BLOCK:             total = len;
      default:                 total = '0;
    endcase
  end

  assign lastByte  = (LEN_W'(idx + 1'b1) == total);
  assign chunkEdge = (proto == PROTO_BLOCK) &&
                     (idx[WIN_IDX_W-1:0] == WIN_IDX_W'(WIN_BYTES - 1));
  assign rxLen     = clipLen(busRxByte);
  assign winSel    = idx[WIN_IDX_W-1:0];
  assign busReq    = (state == S_REQ);
  assign busy      = (state != S_IDLE);

  // operation and byte follow the phase; stable through the wait
  always_comb begin
    busOp     = BUS_SEND;
    busTxByte = '0;
    busRxAck  = 1'b1;
    unique case (phase)
      PH_START, PH_RSTART: busOp = BUS_START;
      PH_QADDR:  busTxByte = addrLat;
      PH_ADDRW:  busTxByte = {addrLat[7:1], 1'b0};
      PH_CMD:    busTxByte = cmdByte;
      PH_BCOUNT: busTxByte = 8'(len);
      PH_WDATA:  busTxByte = winByte;
      PH_ADDRR:  busTxByte = {addrLat[7:1], 1'b1};
      PH_RCOUNT: busOp = BUS_RECV;
      PH_RDATA: begin
        busOp    = BUS_RECV;
        busRxAck = !lastByte;
      end
      PH_STOP:   busOp = BUS_STOP;
      default:   busOp = BUS_STOP;
    endcase
  end

  always_comb begin
    nState = state;  nPhase = phase;  nProto = proto;  nRd = rdMode;
    nAddr  = addrLat; nIdx  = idx;    nLen   = len;    nErr = errEnd;
    nEng   = engaged;
    strb          = '0;
    strb.winIdx   = idx[WIN_IDX_W-1:0];
    strb.countVal = rxLen;
    unique case (state)
      S_IDLE: begin
        if (startStrobe && startProto <= PROTO_BLOCK) begin
          nState = S_REQ;  nPhase = PH_START;  nProto = startProto;
          nRd    = addrByte[0];  nAddr = addrByte;
          nIdx   = '0;  nLen = '0;  nErr = 1'b0;
        end
      end
      S_REQ:  nState = S_WAIT;
      S_HOLD: if (!chunkFlag) nState = S_REQ;
      S_WAIT: begin
        if (busDone) begin
          nState = S_REQ;
          if (busLost) begin
            strb.setColl = 1'b1;
            nState = S_IDLE;
            nEng   = 1'b0;
          end else if (busOp == BUS_SEND && !busAck) begin
            strb.setErr = 1'b1;
            nErr   = 1'b1;
            nPhase = PH_STOP;
          end else begin
            unique case (phase)
              PH_START: begin
                nEng   = 1'b1;
                nPhase = (proto == PROTO_QUICK) ? PH_QADDR : PH_ADDRW;
              end
              PH_QADDR:  nPhase = PH_STOP;
              PH_ADDRW:  nPhase = PH_CMD;
              PH_CMD: begin
                nIdx = '0;
                if (proto == PROTO_PCALL) nPhase = PH_WDATA;
                else if (rdMode) nPhase = PH_RSTART;
                else if (proto == PROTO_BLOCK) begin
                  nPhase = PH_BCOUNT;
                  nLen   = clipLen(countByte);
                end
                else if (proto == PROTO_BYTE) nPhase = PH_STOP;
                else nPhase = PH_WDATA;
              end
              PH_BCOUNT: nPhase = (len == '0) ? PH_STOP : PH_WDATA;
              PH_WDATA: begin
                nIdx = LEN_W'(idx + 1'b1);
                if (lastByte) begin
                  if (proto == PROTO_PCALL) begin
                    nPhase = PH_RSTART;
                    nIdx   = '0;
                  end else nPhase = PH_STOP;
                end else if (chunkEdge) begin
                  strb.setChunk = 1'b1;
                  nState = S_HOLD;
                end
              end
              PH_RSTART: nPhase = PH_ADDRR;
              PH_ADDRR: begin
                nIdx   = '0;
                nPhase = (proto == PROTO_BLOCK) ? PH_RCOUNT : PH_RDATA;
              end
              PH_RCOUNT: begin
                strb.wrCount = 1'b1;
                nLen   = rxLen;
                nPhase = (rxLen == '0) ? PH_STOP : PH_RDATA;
              end
              PH_RDATA: begin
                strb.wrWin = 1'b1;
                nIdx = LEN_W'(idx + 1'b1);
                if (lastByte) nPhase = PH_STOP;
                else if (chunkEdge) begin
                  strb.setChunk = 1'b1;
                  nState = S_HOLD;
                end
              end
              PH_STOP: begin
                nEng   = 1'b0;
                nState = S_IDLE;
                if (!errEnd) strb.setCmpl = 1'b1;
              end
              default: nState = S_IDLE;
            endcase
          end
        end
      end
      default: nState = S_IDLE;
    endcase
    if (killStrobe) begin
      nState = S_IDLE;
      nEng   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      phase   <= PH_START;
      proto   <= '0;
      rdMode  <= 1'b0;
      addrLat <= '0;
      idx     <= '0;
      len     <= '0;
      errEnd  <= 1'b0;
      engaged <= 1'b0;
    end else begin
      state   <= nState;
      phase   <= nPhase;
      proto   <= nProto;
      rdMode  <= nRd;
      addrLat <= nAddr;
      idx     <= nIdx;
      len     <= nLen;
      errEnd  <= nErr;
      engaged <= nEng;
    end
  end

  assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    busReq |=> !busReq);

  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startStrobe) |=> ($stable(proto) && $stable(addrLat)));

  assert_kill_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    killStrobe |=> (!busy && !engaged));

  assert_lost_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && busDone && busLost) |=> (!busy && !busReq));

  assert_hold_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HOLD && chunkFlag) |=> !busReq);

endmodule

// File: rtl/smbus_host.sv
module smbus_host
  import smbus_host_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [3:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       busReq,
  output logic [1:0] busOp,
  output logic [7:0] busTxByte,
  output logic       busRxAck,
  input  logic       busDone,
  input  logic       busAck,
  input  logic       busLost,
  input  logic [7:0] busRxByte
);

  dpStrb_t              strb;
  busOp_e               busOpE;
  logic [WIN_IDX_W-1:0] winSel;
  logic                 startStrobe, killStrobe, chunkFlag, busy, engaged;
  logic [2:0]           startProto;
  logic [7:0]           addrByte, cmdByte, countByte, winByte;

  assign busOp = busOpE;

  smbus_host_regs u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .regWrEn     (regWrEn),
    .regAddr     (regAddr),
    .regWrData   (regWrData),
    .regRdData   (regRdData),
    .strb        (strb),
    .rxByte      (busRxByte),
    .busy        (busy),
    .engaged     (engaged),
    .winSel      (winSel),
    .startStrobe (startStrobe),
    .killStrobe  (killStrobe),
    .startProto  (startProto),
    .addrByte    (addrByte),
    .cmdByte     (cmdByte),
    .countByte   (countByte),
    .winByte     (winByte),
    .chunkFlag   (chunkFlag)
  );

  smbus_host_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startStrobe (startStrobe),
    .killStrobe  (killStrobe),
    .startProto  (startProto),
    .addrByte    (addrByte),
    .cmdByte     (cmdByte),
    .countByte   (countByte),
    .winByte     (winByte),
    .chunkFlag   (chunkFlag),
    .busReq      (busReq),
    .busOp       (busOpE),
    .busTxByte   (busTxByte),
    .busRxAck    (busRxAck),
    .busDone     (busDone),
    .busAck      (busAck),
    .busLost     (busLost),
    .busRxByte   (busRxByte),
    .strb        (strb),
    .winSel      (winSel),
    .busy        (busy),
    .engaged     (engaged)
  );

endmodule

// File: tb/smbus_host_tb.sv
module smbus_host_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       busReq;
  logic [1:0] busOp;
  logic [7:0] busTxByte;
  logic       busRxAck;
  logic       busDone = 1'b0;
  logic       busAck = 1'b1;
  logic       busLost = 1'b0;
  logic [7:0] busRxByte = '0;

  always #5 clk = ~clk;

  smbus_host u_dut (.*);

  typedef struct {
    logic [1:0] op;
    logic [7:0] data;
    logic       ack;
    string      tag;
  } expItem_t;

  expItem_t   expQ[$];
  logic [7:0] rxQ[$];
  int nChecks = 0;
  int nFail = 0;
  int sendCount = 0;
  int opCount = 0;
  int nackAt = -1;
  int loseAt = -1;
  bit pend = 0;
  logic [1:0] pendOp = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] d, input logic a, input string tag);
    expItem_t it;
    it.op = op; it.data = d; it.ack = a; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic eStart(input string t); push(2'd0, 8'h00, 1'b0, t); endtask
  task automatic eSend(input logic [7:0] d, input string t); push(2'd1, d, 1'b0, t); endtask
  task automatic eRecv(input logic a, input string t); push(2'd2, 8'h00, a, t); endtask
  task automatic eStop(input string t); push(2'd3, 8'h00, 1'b0, t); endtask

  // bus model and scoreboard monitor, away from the active edge
  always @(negedge clk) begin
    if (!rstN) begin
      busDone = 1'b0;
      pend = 0;
    end else begin
      busDone = 1'b0;
      if (pend) begin
        pend = 0;
        busDone = 1'b1;
        busLost = (opCount == loseAt);
        busAck = !(pendOp == 2'd1 && sendCount == nackAt);
        if (pendOp == 2'd2) busRxByte = (rxQ.size() > 0) ? rxQ.pop_front() : 8'hEE;
        if (pendOp == 2'd1) sendCount++;
        opCount++;
      end
      if (busReq) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R12 unexpected bus op", int'(busOp), 4);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          eq(it.tag, int'(busOp), int'(it.op));
          if (it.op == 2'd1) eq(it.tag, int'(busTxByte), int'(it.data));
          if (it.op == 2'd2) eq(it.tag, int'(busRxAck), int'(it.ack));
        end
        pend = 1;
        pendOp = busOp;
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitIdle();
    logic [7:0] d;
    for (int i = 0; i < 3000; i++) begin
      rd(4'h2, d);
      if (!d[0]) break;
    end
  endtask

  task automatic waitChunk();
    logic [7:0] d;
    for (int i = 0; i < 3000; i++) begin
      rd(4'h0, d);
      if (d[4]) break;
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL R11 watchdog: actual 0x0 expected 0x1");
    finishRun();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(4'h0, d); eq("R1 status", d, 8'h00);
    rd(4'h2, d); eq("R1 control", d, 8'h00);
    rd(4'h3, d); eq("R1 host control", d, 8'h00);
    rd(4'h7, d); eq("R1 count", d, 8'h00);
    rd(4'h4, d); eq("R1 address", d, 8'h00);
    eq("R1 no request", busReq, 0);

    // R2 quick write
    wr(4'h4, 8'hA0);
    eStart("R2 start"); eSend(8'hA0, "R2 addr"); eStop("R2 stop");
    wr(4'h3, 8'h10);
    waitIdle();
    rd(4'h0, d); eq("R2 completion", d, 8'h08);
    // R10 zero write keeps, one write clears
    wr(4'h0, 8'h00); rd(4'h0, d); eq("R10 zero write keeps", d, 8'h08);
    wr(4'h0, 8'h08); rd(4'h0, d); eq("R10 one write clears", d, 8'h00);

    // R3 byte-data write
    wr(4'h5, 8'h3C); wr(4'h8, 8'h5A);
    eStart("R3 start"); eSend(8'hA0, "R3 addr"); eSend(8'h3C, "R3 cmd");
    eSend(8'h5A, "R3 data"); eStop("R3 stop");
    wr(4'h3, 8'h12);
    waitIdle();
    rd(4'h0, d); eq("R3 completion", d, 8'h08);
    wr(4'h0, 8'h1E);

    // R3 word write, low byte first
    wr(4'h8, 8'hC1); wr(4'h9, 8'hC2);
    eStart("R3 w start"); eSend(8'hA0, "R3 w addr"); eSend(8'h3C, "R3 w cmd");
    eSend(8'hC1, "R3 w low"); eSend(8'hC2, "R3 w high"); eStop("R3 w stop");
    wr(4'h3, 8'h13);
    waitIdle();
    wr(4'h0, 8'h1E);

    // R3 byte protocol, write form
    wr(4'h5, 8'h77);
    eStart("R3 b start"); eSend(8'hA0, "R3 b addr"); eSend(8'h77, "R3 b cmd"); eStop("R3 b stop");
    wr(4'h3, 8'h11);
    waitIdle();
    rd(4'h0, d); eq("R3 byte completion", d, 8'h08);
    wr(4'h0, 8'h1E);

    // R4 word read
    wr(4'h4, 8'hA1); wr(4'h5, 8'h10);
    rxQ.push_back(8'h34); rxQ.push_back(8'h12);
    eStart("R4 start"); eSend(8'hA0, "R4 addr w"); eSend(8'h10, "R4 cmd");
    eStart("R4 restart"); eSend(8'hA1, "R4 addr r");
    eRecv(1'b1, "R4 ack first"); eRecv(1'b0, "R4 nack last"); eStop("R4 stop");
    wr(4'h3, 8'h13);
    waitIdle();
    rd(4'h8, d); eq("R4 low byte", d, 8'h34);
    rd(4'h9, d); eq("R4 high byte", d, 8'h12);
    wr(4'h0, 8'h1E);

    // R5 process call (address read flag low)
    wr(4'h4, 8'hA0); wr(4'h5, 8'h22); wr(4'h8, 8'h11); wr(4'h9, 8'h22);
    rxQ.push_back(8'h99); rxQ.push_back(8'h88);
    eStart("R5 start"); eSend(8'hA0, "R5 addr"); eSend(8'h22, "R5 cmd");
    eSend(8'h11, "R5 tx low"); eSend(8'h22, "R5 tx high");
    eStart("R5 restart"); eSend(8'hA1, "R5 addr r");
    eRecv(1'b1, "R5 rx low"); eRecv(1'b0, "R5 rx high"); eStop("R5 stop");
    wr(4'h3, 8'h14);
    waitIdle();
    rd(4'h8, d); eq("R5 low back", d, 8'h99);
    rd(4'h9, d); eq("R5 high back", d, 8'h88);
    wr(4'h0, 8'h1E);

    // R8 nack on address
    nackAt = sendCount;
    wr(4'h4, 8'hB0);
    eStart("R8 start"); eSend(8'hB0, "R8 addr"); eStop("R8 stop");
    wr(4'h3, 8'h12);
    waitIdle();
    rd(4'h0, d); eq("R8 device error only", d, 8'h02);
    wr(4'h0, 8'h1E);
    nackAt = -1;

    // R9 arbitration loss on the command byte
    loseAt = opCount + 2;
    wr(4'h4, 8'hA0);
    eStart("R9 start"); eSend(8'hA0, "R9 addr"); eSend(8'h22, "R9 cmd");
    wr(4'h3, 8'h11);
    waitIdle();
    repeat (5) @(negedge clk);
    rd(4'h0, d); eq("R9 collision only", d, 8'h04);
    rd(4'h2, d); eq("R9 bus released", d, 8'h00);
    eq("R9 no stop", expQ.size(), 0);
    wr(4'h0, 8'h1E);
    loseAt = -1;

    // R6 block write of 10 bytes, with R11 start ignored during the pause
    wr(4'h5, 8'h61); wr(4'h7, 8'd10);
    for (int i = 0; i < 8; i++) wr(4'(8 + i), 8'(8'h40 + i));
    eStart("R6 start"); eSend(8'hA0, "R6 addr"); eSend(8'h61, "R6 cmd");
    eSend(8'd10, "R6 count");
    for (int i = 0; i < 8; i++) eSend(8'(8'h40 + i), "R6 chunk0");
    wr(4'h3, 8'h15);
    waitChunk();
    repeat (6) @(negedge clk);
    eq("R6 paused after chunk", expQ.size(), 0);
    rd(4'h2, d); eq("R14 busy and engaged", d, 8'h03);
    wr(4'h3, 8'h10);
    rd(4'h3, d); eq("R11 protocol kept", d, 8'h05);
    wr(4'h8, 8'h50); wr(4'h9, 8'h51);
    eSend(8'h50, "R6 chunk1"); eSend(8'h51, "R6 chunk1"); eStop("R6 stop");
    wr(4'h0, 8'h10);
    waitIdle();
    rd(4'h0, d); eq("R6 completion no chunk", d, 8'h08);
    eq("R11 no extra ops", expQ.size(), 0);
    wr(4'h0, 8'h1E);

    // R6 block write of zero length
    wr(4'h7, 8'd0);
    eStart("R6 z start"); eSend(8'hA0, "R6 z addr"); eSend(8'h61, "R6 z cmd");
    eSend(8'd0, "R6 z count"); eStop("R6 z stop");
    wr(4'h3, 8'h15);
    waitIdle();
    wr(4'h0, 8'h1E);

    // R7 block read, count 40 clipped to 32
    wr(4'h4, 8'hA1); wr(4'h5, 8'h30);
    rxQ.push_back(8'd40);
    for (int i = 0; i < 32; i++) rxQ.push_back(8'(8'h80 + i));
    eStart("R7 start"); eSend(8'hA0, "R7 addr w"); eSend(8'h30, "R7 cmd");
    eStart("R7 restart"); eSend(8'hA1, "R7 addr r"); eRecv(1'b1, "R7 count ack");
    for (int i = 0; i < 32; i++) eRecv(i != 31, "R7 data ack");
    eStop("R7 stop");
    wr(4'h3, 8'h15);
    for (int c = 0; c < 4; c++) begin
      if (c < 3) waitChunk(); else waitIdle();
      for (int j = 0; j < 8; j++) begin
        rd(4'(8 + j), d);
        eq("R7 window data", d, 8'h80 + 8 * c + j);
      end
      if (c < 3) wr(4'h0, 8'h10);
    end
    rd(4'h7, d); eq("R7 clipped count", d, 8'd32);
    rd(4'h0, d); eq("R7 completion", d, 8'h08);
    wr(4'h0, 8'h1E);

    // R12 kill during a block pause
    wr(4'h4, 8'hA0); wr(4'h7, 8'd10);
    eStart("R12 start"); eSend(8'hA0, "R12 addr"); eSend(8'h30, "R12 cmd");
    eSend(8'd10, "R12 count");
    for (int i = 0; i < 8; i++) eSend(8'(8'h80 + 8 * 3 + i), "R12 chunk0");
    wr(4'h3, 8'h15);
    waitChunk();
    wr(4'h3, 8'h20);
    rd(4'h2, d); eq("R12 idle after kill", d, 8'h00);
    wr(4'h0, 8'h1E);
    repeat (20) @(negedge clk);
    eq("R12 no ops after kill", expQ.size(), 0);
    rd(4'h0, d); eq("R12 no completion", d, 8'h00);

    // R13 reserved protocol codes
    wr(4'h3, 8'h16);
    rd(4'h2, d); eq("R13 code 6 ignored", d, 8'h00);
    wr(4'h3, 8'h17);
    repeat (10) @(negedge clk);
    rd(4'h2, d); eq("R13 code 7 ignored", d, 8'h00);

    // R14 control storage bits
    wr(4'h2, 8'h60); rd(4'h2, d); eq("R14 stored bits", d, 8'h60);
    wr(4'h2, 8'hFF); rd(4'h2, d); eq("R14 status bits not writable", d, 8'h60);

    repeat (5) @(negedge clk);
    eq("R11 scoreboard drained", expQ.size(), 0);
    finishRun();
  end

endmodule